// File: doc/BRIEF.md
# Machine Trap Vector Address Generator

This block keeps the machine-mode trap vector control register and turns an incoming trap request into the program counter value that the fetch stage must jump to. The register has two fields. A two-bit operating mode sits in the least significant bits. A word-aligned handler base address fills the bits above it. Software reaches the register through a simple register port with a select, a write strobe, write data and combinational read data.

A trap request arrives with a valid strobe, a flag that separates asynchronous interrupts from synchronous exceptions, and a five-bit cause code. In direct mode every trap lands on the base address. In vectored mode an interrupt lands on the base plus four times its cause code. An exception still lands on the base. All machine external interrupts share cause 11, so they all use the one slot at offset 0x2C.

Writes are legalized before they are stored, so the register never holds an illegal value. A reserved mode value is dropped. A vectored base is forced onto a 128-byte boundary.

Top module: `tvec_gen`

## Requirements
- R1: After reset the register holds mode 0 (direct) and base 0, so a selected read returns 0x00000000.
- R2: A write (csr_sel=1, csr_we=1) whose data bits [1:0] are 0 stores bits [31:2] as the base, and a later selected read returns the written word unchanged.
- R3: A write whose data bits [1:0] are 2 or 3 (reserved modes) leaves the stored mode unchanged, while the base is still taken from data bits [31:2] and legalized against the retained mode.
- R4: Whenever the resulting mode is 1 (vectored), base bits [6:2] are stored as zero, so the base is 128-byte aligned, and read data shows mode 1 in bits [1:0].
- R5: In mode 0 every valid trap, interrupt or exception, with any cause, drives trap_target to the base address with bits [1:0] zero.
- R6: In mode 1 a valid trap with trap_is_irq=1 drives trap_target to base + (trap_cause << 2), computed modulo 2^32.
- R7: In mode 1 a valid trap with trap_is_irq=0 (synchronous exception) drives trap_target to the base, with no cause offset.
- R8: In mode 1 the machine timer interrupt (cause 7) targets base + 0x1C, and every machine external interrupt (cause 11) targets the single slot base + 0x2C.
- R9: trap_target is combinational and valid in the same cycle as trap_valid. It is 0 whenever trap_valid is 0.
- R10: When csr_sel=0 or csr_we=0, the register keeps its contents. When csr_sel=0, csr_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_sel | input | 1 | Register address match |
| csr_we | input | 1 | Write strobe, used only with csr_sel |
| csr_wdata | input | 32 | Write data: bits [1:0] mode, bits [31:2] base |
| csr_rdata | output | 32 | Legalized register value when selected, otherwise 0 |
| trap_valid | input | 1 | A trap is being taken this cycle |
| trap_is_irq | input | 1 | 1 for an asynchronous interrupt, 0 for an exception |
| trap_cause | input | 5 | Cause code of the trap |
| trap_target | output | 32 | Program counter target for the trap |

## Verification
The assertions check on every cycle the properties that hold at all times. The vectored base is always aligned. Exceptions and direct-mode traps land on the base. An idle request drives a zero target. A cycle with no write, or with a reserved-mode write, leaves the stored mode as it was. Only the bench's scenarios can show that each individual value is right: the exact word read back after each kind of write, the retention of a mode across a reserved write, and the arithmetic of each vectored offset. These cases include the timer slot, the shared external slot and the largest cause at the top of the address space. The bench gets them by comparing against its own model on every clock.

// File: rtl/tvec_pkg.sv
package tvec_pkg;

  // Legal operating modes of the trap vector register
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_VECTORED = 2'd1
  } tvec_mode_e;

  // True for the mode encodings the register may hold
  function automatic logic mode_is_legal(input logic [1:0] m);
    return (m == 2'd0) || (m == 2'd1);
  endfunction

endpackage

// File: rtl/tvec_csr.sv
module tvec_csr
  import tvec_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ALIGN_LOG2 = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  output tvec_mode_e      mode_q,
  output logic [XLEN-3:0] base_q
);

  // Number of base-field bits cleared for vectored alignment
  localparam int CLR_BITS = ALIGN_LOG2 - 2;

  logic [XLEN-3:0] align_mask;
  tvec_mode_e      nxt_mode;
  logic [XLEN-3:0] nxt_base;

  generate
    if (CLR_BITS > 0) begin : g_mask
      assign align_mask = {{(XLEN-2-CLR_BITS){1'b0}}, {CLR_BITS{1'b1}}};
    end else begin : g_nomask
      assign align_mask = '0;
    end
  endgenerate

  // Legalize: a reserved mode is dropped, and a vectored base is aligned
  always_comb begin
    nxt_mode = mode_is_legal(wdata[1:0]) ? tvec_mode_e'(wdata[1:0]) : mode_q;
    nxt_base = wdata[XLEN-1:2];
    if (nxt_mode == MODE_VECTORED) nxt_base = nxt_base & ~align_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_DIRECT;
      base_q <= '0;
    end else if (wr_en) begin
      mode_q <= nxt_mode;
      base_q <= nxt_base;
    end
  end

endmodule

// File: rtl/tvec_target.sv
module tvec_target
  import tvec_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  tvec_mode_e          mode,
  input  logic [XLEN-3:0]     base,
  input  logic                trap_valid,
  input  logic                trap_is_irq,
  input  logic [CAUSE_W-1:0]  trap_cause,
  output logic                vec_hit,
  output logic [XLEN-1:0]     target
);

  // Byte offset of a vector slot: four bytes per cause code
  function automatic logic [XLEN-1:0] slot_offset(input logic [CAUSE_W-1:0] c);
    return {{(XLEN-CAUSE_W-2){1'b0}}, c, 2'b00};
  endfunction

  logic [XLEN-1:0] base_addr;

  assign base_addr = {base, 2'b00};
  assign vec_hit   = trap_valid && trap_is_irq && (mode == MODE_VECTORED);

  always_comb begin
    if (!trap_valid)  target = '0;
    else if (vec_hit) target = base_addr + slot_offset(trap_cause);
    else              target = base_addr;
  end

endmodule

// File: rtl/tvec_gen.sv
module tvec_gen
  import tvec_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 5,
  parameter int ALIGN_LOG2 = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_sel,
  input  logic               csr_we,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  input  logic               trap_valid,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_target
);

  tvec_mode_e      mode_q;
  logic [XLEN-3:0] base_q;
  logic [1:0]      mode_bits;
  logic            csr_write;
  logic            vec_hit;

  assign csr_write = csr_sel & csr_we;
  assign mode_bits = mode_q;

  tvec_csr #(.XLEN(XLEN), .ALIGN_LOG2(ALIGN_LOG2)) u_csr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (csr_write),
    .wdata  (csr_wdata),
    .mode_q (mode_q),
    .base_q (base_q)
  );

  tvec_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_tgt (
    .mode        (mode_q),
    .base        (base_q),
    .trap_valid  (trap_valid),
    .trap_is_irq (trap_is_irq),
    .trap_cause  (trap_cause),
    .vec_hit     (vec_hit),
    .target      (trap_target)
  );

  assign csr_rdata = csr_sel ? {base_q, mode_bits} : '0;

endmodule

// File: rtl/tvec_chk.sv
module tvec_chk #(
  parameter int XLEN       = 32,
  parameter int ALIGN_LOG2 = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_write,
  input logic [1:0]      wdata_mode,
  input logic [1:0]      mode_bits,
  input logic [XLEN-3:0] base_q,
  input logic            trap_valid,
  input logic            trap_is_irq,
  input logic            vec_hit,
  input logic [XLEN-1:0] trap_target
);

  // R3
  reserved_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_write && wdata_mode[1]) |=> $stable(mode_bits));

  // R4
  vec_base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 2'd1) |-> (base_q[ALIGN_LOG2-3:0] == '0));

  // R5
  direct_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && mode_bits == 2'd0) |-> (trap_target == {base_q, 2'b00}));

  // R7
  exception_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_is_irq) |-> (trap_target == {base_q, 2'b00}));

  // R6
  vector_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit |-> (trap_target[XLEN-1:ALIGN_LOG2] == base_q[XLEN-3:ALIGN_LOG2-2]
                 && trap_target[1:0] == 2'b00));

  // R9
  idle_target_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> (trap_target == '0));

  // R10
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_write |=> ($stable(mode_bits) && $stable(base_q)));

endmodule

bind tvec_gen tvec_chk #(.XLEN(XLEN), .ALIGN_LOG2(ALIGN_LOG2)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_write   (csr_write),
  .wdata_mode  (csr_wdata[1:0]),
  .mode_bits   (mode_bits),
  .base_q      (base_q),
  .trap_valid  (trap_valid),
  .trap_is_irq (trap_is_irq),
  .vec_hit     (vec_hit),
  .trap_target (trap_target)
);

// File: tb/tb_tvec_gen.sv
`timescale 1ns/1ps
module tb_tvec_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_sel = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        trap_valid = 1'b0;
  logic        trap_is_irq = 1'b0;
  logic [4:0]  trap_cause = '0;
  logic [31:0] trap_target;

  int compared = 0;
  int mismatched = 0;

  // Behavioural reference state
  int unsigned ref_mode = 0;
  int unsigned ref_base = 0;

  always #10 clk = ~clk;

  tvec_gen dut (
    .clk(clk), .rst_n(rst_n),
    .csr_sel(csr_sel), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .trap_valid(trap_valid), .trap_is_irq(trap_is_irq), .trap_cause(trap_cause),
    .trap_target(trap_target)
  );

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare, then update the model at the rising edge
  task automatic cyc(input logic sel, input logic we, input logic [31:0] wd,
                     input logic tv, input logic irq, input logic [4:0] cause,
                     input string tag);
    int unsigned exp_rd;
    int unsigned exp_tg;
    @(negedge clk);
    csr_sel = sel; csr_we = we; csr_wdata = wd;
    trap_valid = tv; trap_is_irq = irq; trap_cause = cause;
    #2;
    exp_rd = sel ? (ref_base | ref_mode) : 0;
    if (!tv) exp_tg = 0;
    else if (ref_mode == 1 && irq) exp_tg = ref_base + 4 * int'(cause);
    else exp_tg = ref_base;
    cmp(tag, "csr_rdata", csr_rdata, exp_rd);
    cmp(tag, "trap_target", trap_target, exp_tg);
    @(posedge clk);
    if (rst_n && sel && we) begin
      if ((wd & 3) < 2) ref_mode = wd & 3;
      ref_base = wd & 32'hFFFF_FFFC;
      if (ref_mode == 1) ref_base = ref_base & 32'hFFFF_FF80;
    end
  endtask

  initial begin
    #(20 * 5000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    cyc(1, 0, 0, 1, 1, 5'd7, "R1");
    // R2 direct write and readback
    cyc(1, 1, 32'h8000_1234, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, 0, "R2");
    // R5 direct mode traps
    cyc(0, 0, 0, 1, 1, 5'd7, "R5");
    cyc(0, 0, 0, 1, 0, 5'd2, "R5");
    cyc(0, 0, 0, 1, 1, 5'd31, "R5");
    // R4 vectored write aligns base
    cyc(1, 1, 32'h8000_1235, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, 0, 0, "R4");
    // R8 timer and shared external slot
    cyc(0, 0, 0, 1, 1, 5'd7, "R8");
    cyc(0, 0, 0, 1, 1, 5'd11, "R8");
    // R6 other causes
    cyc(0, 0, 0, 1, 1, 5'd3, "R6");
    cyc(0, 0, 0, 1, 1, 5'd31, "R6");
    cyc(0, 0, 0, 1, 1, 5'd0, "R6");
    // R7 exceptions in vectored mode
    cyc(0, 0, 0, 1, 0, 5'd11, "R7");
    cyc(0, 0, 0, 1, 0, 5'd7, "R7");
    // R9 idle request
    cyc(0, 0, 0, 0, 1, 5'd11, "R9");
    // R3 reserved mode writes keep mode 1
    cyc(1, 1, 32'h4000_0FFE, 0, 0, 0, "R3");
    cyc(1, 0, 0, 1, 1, 5'd11, "R3");
    cyc(1, 1, 32'h4000_00F3, 0, 0, 0, "R3");
    cyc(1, 0, 0, 1, 1, 5'd5, "R3");
    // R10 ignored writes and deselected read
    cyc(0, 1, 32'h1234_5670, 0, 0, 0, "R10");
    cyc(1, 0, 32'h1234_5670, 0, 0, 0, "R10");
    cyc(1, 0, 0, 1, 1, 5'd1, "R10");
    // R5 back to direct, unaligned base kept
    cyc(1, 1, 32'h0000_0FFC, 0, 0, 0, "R5");
    cyc(1, 0, 0, 1, 1, 5'd7, "R5");
    // R3 reserved write from direct keeps direct, base unaligned
    cyc(1, 1, 32'h0000_0106, 0, 0, 0, "R3");
    cyc(1, 0, 0, 1, 1, 5'd9, "R3");
    // R6 top of address space
    cyc(1, 1, 32'hFFFF_FFFD, 0, 0, 0, "R6");
    cyc(1, 0, 0, 1, 1, 5'd31, "R6");
    cyc(0, 0, 0, 0, 0, 0, "R9");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule